// File: doc/BRIEF.md
# Saturating Wiper Position Controller

This block is the digital control section of a 32-position digitally trimmed resistor divider. A host drives three slow level inputs: an active-low select, a direction level and a step strobe. While the block is selected, every high-to-low transition of the strobe moves a 5-bit wiper position one place. The direction level decides whether it moves up or down. The position stops at either end and never wraps.

When the host releases select, the strobe level at that moment decides what happens. A high strobe commits the position to a modelled non-volatile register and starts a timed store phase. A low strobe leaves the position live but uncommitted. Reset stands in for power-up and reloads the position from the committed register. The register starts at a parameterised default value. The position drives a 32-bit tap-enable vector. In steady state exactly one bit is set. After every move the previous tap stays on for a short overlap window, so the path never breaks.

A controller FSM has three named states. IDLE (deselected) goes to ACTIVE when the synchronised select goes low. ACTIVE steps on each strobe fall and leaves on select release: to STORE if the strobe is high (commit), to IDLE if it is low (discard). STORE counts down the store time with busy raised, ignores all inputs and returns to IDLE when the timer expires.

Top module: `dcp_wiper_ctrl`

## Requirements
- R1: While the synchronised select is high (deselected), strobe transitions leave the position unchanged.
- R2: While selected, each falling strobe edge changes the position by exactly one: up when the direction input is 1, down when it is 0. Rising strobe edges have no effect.
- R3: The position saturates at 0 and at TAPS-1 (31). A step past either end leaves it unchanged.
- R4: Releasing select while the strobe is high copies the position into the committed register. Busy is then high for exactly STORE_CYCLES clock cycles.
- R5: Releasing select while the strobe is low stores nothing and does not raise busy. The live position is kept until it is moved again or a reset reloads the committed value.
- R6: While busy is high, the select, direction and strobe inputs are ignored: no step, no new store.
- R7: Reset loads the position from the committed register. Before any store, that register holds DEFAULT_POS.
- R8: In steady state tap_en_o has exactly one bit set, at the index equal to wiper_o.
- R9: After a move, the old and new tap bits are both set for exactly OVERLAP_CYCLES cycles, starting with the cycle in which wiper_o changes. The new tap never turns off during that time.
- R10: The direction input may change while select stays low. Later steps follow the new direction with no deselect in between.
- R11: Every input passes a two-flop synchroniser. The position changes on the third rising clock edge after the strobe falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up recall) |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| dir_i | input | 1 | Direction: 1 up, 0 down, asynchronous |
| inc_i | input | 1 | Step strobe, falling edge steps, asynchronous |
| wiper_o | output | 5 | Current wiper position |
| tap_en_o | output | 32 | Tap-enable vector, one-hot in steady state |
| busy_o | output | 1 | High during the store phase |

## Verification
The bench builds the block with 32 taps, a default position of 16, STORE_CYCLES of 40 and OVERLAP_CYCLES of 3. The short store time means the full busy window can be counted cycle by cycle. It also leaves room to drive a complete select, strobe and release sequence inside the window to show that the window ignores its inputs. An overlap of 3 keeps the make-before-break window long enough to count exactly, yet brief compared with the strobe period, so the old and new taps can be seen together and then apart. The mid-scale default puts both saturation ends within a few dozen strobes of reset.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;

    // Controller states
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_ACTIVE = 2'd1,
        WS_STORE  = 2'd2
    } wstate_t;

endpackage

// File: rtl/in_sync.sv
module in_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q[gi] <= RST_VAL[gi];
                    stab_q[gi] <= RST_VAL[gi];
                end else begin
                    meta_q[gi] <= d_i[gi];
                    stab_q[gi] <= meta_q[gi];
                end
            end
        end
    endgenerate

    assign q_o = stab_q;

endmodule

// File: rtl/wiper_fsm.sv
module wiper_fsm
    import tapctl_pkg::*;
#(
    parameter int STORE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_s,
    input  logic dir_s,
    input  logic inc_s,
    output logic step_o,
    output logic up_o,
    output logic commit_o,
    output logic busy_o
);

    localparam int CNT_W = (STORE_CYCLES > 1) ? $clog2(STORE_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STORE_CYCLES - 1);

    wstate_t          state_q, state_d;
    logic [CNT_W-1:0] store_cnt_q;
    logic             inc_prev_q;
    logic             inc_fall;

    assign inc_fall = inc_prev_q && !inc_s;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Strobe history and store timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_prev_q  <= 1'b1;
            store_cnt_q <= '0;
        end else begin
            inc_prev_q <= inc_s;
            if (commit_o) begin
                store_cnt_q <= CNT_LOAD;
            end else if (state_q == WS_STORE && store_cnt_q != '0) begin
                store_cnt_q <= store_cnt_q - 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: begin
                if (!sel_n_s) state_d = WS_ACTIVE;
            end
            WS_ACTIVE: begin
                if (sel_n_s) state_d = inc_s ? WS_STORE : WS_IDLE;
            end
            WS_STORE: begin
                if (store_cnt_q == '0) state_d = WS_IDLE;
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        step_o   = 1'b0;
        up_o     = dir_s;
        commit_o = 1'b0;
        busy_o   = 1'b0;
        unique case (state_q)
            WS_IDLE: ;
            WS_ACTIVE: begin
                step_o   = !sel_n_s && inc_fall;
                commit_o = sel_n_s && inc_s;
            end
            WS_STORE: begin
                busy_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R1
    deselect_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |-> !step_o);

    // R4
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> busy_o);

    // R6
    busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!step_o && !commit_o));

    // R4
    store_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && store_cnt_q != '0) |=> busy_o);

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
    parameter int TAPS = 32,
    parameter int POS_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] load_val_i,
    input  logic             step_i,
    input  logic             up_i,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [POS_W-1:0] MAX_POS = POS_W'(TAPS - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= load_val_i;
        end else if (step_i) begin
            if (up_i && pos_q != MAX_POS) begin
                pos_q <= pos_q + 1'b1;
            end else if (!up_i && pos_q != '0) begin
                pos_q <= pos_q - 1'b1;
            end
        end
    end

    assign pos_o = pos_q;

    // R3
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && up_i && pos_q == MAX_POS) |=> pos_q == MAX_POS);

    // R3
    bottom_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !up_i && pos_q == '0) |=> pos_q == '0);

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && up_i && pos_q != MAX_POS) |=> pos_q == $past(pos_q) + 1'b1);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pos_q));

endmodule

// File: rtl/tap_overlap_decoder.sv
module tap_overlap_decoder #(
    parameter int TAPS = 32,
    parameter int POS_W = $clog2(TAPS),
    parameter int OVERLAP_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_i,
    output logic [TAPS-1:0]  tap_en_o
);

    localparam int OV_W = (OVERLAP_CYCLES > 1) ? $clog2(OVERLAP_CYCLES) : 1;
    localparam logic [OV_W-1:0] OV_LOAD = OV_W'(OVERLAP_CYCLES - 1);

    logic [POS_W-1:0] last_q;
    logic [POS_W-1:0] hold_q;
    logic [OV_W-1:0]  ovl_cnt_q;

    function automatic logic [TAPS-1:0] onehot(input logic [POS_W-1:0] p);
        logic [TAPS-1:0] v;
        v    = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q    <= pos_i;
            hold_q    <= pos_i;
            ovl_cnt_q <= '0;
        end else begin
            last_q <= pos_i;
            if (pos_i != last_q) begin
                hold_q    <= last_q;
                ovl_cnt_q <= OV_LOAD;
            end else if (ovl_cnt_q != '0) begin
                ovl_cnt_q <= ovl_cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        tap_en_o = onehot(pos_i) | onehot(last_q);
        if (ovl_cnt_q != '0) begin
            tap_en_o = tap_en_o | onehot(hold_q);
        end
    end

    // R9
    make_before_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i != $past(pos_i)) |-> tap_en_o[$past(pos_i)]);

    // R8
    steady_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_cnt_q == '0 && pos_i == last_q) |-> ($countones(tap_en_o) == 1 && tap_en_o[pos_i]));

endmodule

// File: rtl/dcp_wiper_ctrl.sv
module dcp_wiper_ctrl #(
    parameter int TAPS           = 32,
    parameter int DEFAULT_POS    = 16,
    parameter int STORE_CYCLES   = 1000,
    parameter int OVERLAP_CYCLES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n_i,
    input  logic                    dir_i,
    input  logic                    inc_i,
    output logic [$clog2(TAPS)-1:0] wiper_o,
    output logic [TAPS-1:0]         tap_en_o,
    output logic                    busy_o
);

    localparam int POS_W = $clog2(TAPS);

    logic [2:0]       raw_in;
    logic [2:0]       syn_in;
    logic             step;
    logic             step_up;
    logic             commit;
    logic [POS_W-1:0] pos;

    // Modelled non-volatile register: no reset, initial default
    logic [POS_W-1:0] nv_q = POS_W'(DEFAULT_POS);

    assign raw_in = {sel_n_i, inc_i, dir_i};

    in_sync #(
        .W       (3),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    wiper_fsm #(
        .STORE_CYCLES (STORE_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_s  (syn_in[2]),
        .dir_s    (syn_in[0]),
        .inc_s    (syn_in[1]),
        .step_o   (step),
        .up_o     (step_up),
        .commit_o (commit),
        .busy_o   (busy_o)
    );

    wiper_counter #(
        .TAPS  (TAPS),
        .POS_W (POS_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_val_i (nv_q),
        .step_i     (step),
        .up_i       (step_up),
        .pos_o      (pos)
    );

    always_ff @(posedge clk) begin
        if (commit) begin
            nv_q <= pos;
        end
    end

    tap_overlap_decoder #(
        .TAPS           (TAPS),
        .POS_W          (POS_W),
        .OVERLAP_CYCLES (OVERLAP_CYCLES)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos_i    (pos),
        .tap_en_o (tap_en_o)
    );

    assign wiper_o = pos;

    // R4
    commit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> nv_q == $past(pos));

    // R5
    nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(nv_q));

endmodule

// File: tb/dcp_wiper_ctrl_test.sv
module dcp_wiper_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 32;
    localparam int DEF_POS    = 16;
    localparam int STORE_CYC  = 40;
    localparam int OVL_CYC    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        dir = 1'b0;
    logic        inc = 1'b1;
    logic [4:0]  wiper;
    logic [31:0] tap_en;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int busy_cnt = 0;

    // Step table: {direction, expected position after the step}
    localparam logic [5:0] VEC [10] = '{
        {1'b1, 5'd18}, {1'b1, 5'd19}, {1'b0, 5'd18}, {1'b1, 5'd19},
        {1'b0, 5'd18}, {1'b0, 5'd17}, {1'b0, 5'd16}, {1'b0, 5'd15},
        {1'b1, 5'd16}, {1'b1, 5'd17}
    };

    always #(CLK_PERIOD / 2) clk = ~clk;

    dcp_wiper_ctrl #(
        .TAPS           (TAPS),
        .DEFAULT_POS    (DEF_POS),
        .STORE_CYCLES   (STORE_CYC),
        .OVERLAP_CYCLES (OVL_CYC)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_i  (sel_n),
        .dir_i    (dir),
        .inc_i    (inc),
        .wiper_o  (wiper),
        .tap_en_o (tap_en),
        .busy_o   (busy)
    );

    always @(negedge clk) if (busy) busy_cnt++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
    endtask

    task automatic pulse(input logic d);
        dir = d;
        wait_n(3);
        inc = 1'b0;
        wait_n(5);
        inc = 1'b1;
        wait_n(5);
    endtask

    task automatic select();
        sel_n = 1'b0;
        wait_n(4);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        wait_n(150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int old_pos;
        int n;
        do_reset();
        // R7: default committed value after first reset; R8 one-hot
        chk("R7 reset pos", wiper, DEF_POS);
        chk("R8 reset taps", tap_en, 64'(32'h1 << DEF_POS));
        chk("R7 reset busy", busy, 0);

        // R1: strobe while deselected
        pulse(1'b1);
        pulse(1'b1);
        chk("R1 deselected", wiper, DEF_POS);

        // R11: latency of three rising edges
        select();
        dir = 1'b1;
        wait_n(3);
        inc = 1'b0;
        wait_n(2);
        chk("R11 no change after 2 edges", wiper, DEF_POS);
        wait_n(1);
        chk("R11 change after 3 edges", wiper, DEF_POS + 1);
        wait_n(3);
        inc = 1'b1;
        wait_n(5);
        chk("R2 rising edge no effect", wiper, DEF_POS + 1);

        // R2 / R10: table of steps with direction changes, select held low
        for (int k = 0; k < 10; k++) begin
            pulse(VEC[k][5]);
            chk("R2 R10 table step", wiper, VEC[k][4:0]);
            chk("R8 steady tap", tap_en, 64'(32'h1 << VEC[k][4:0]));
        end

        // R9: overlap window on one up step from 17
        dir = 1'b1;
        wait_n(3);
        old_pos = wiper;
        inc = 1'b0;
        n = 0;
        while (wiper == old_pos && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk("R9 moved", wiper, old_pos + 1);
        n = 0;
        while (tap_en == ((32'h1 << old_pos) | (32'h1 << (old_pos + 1))) && n < 10) begin
            n++;
            @(negedge clk);
        end
        chk("R9 overlap cycles", n, OVL_CYC);
        chk("R9 new tap alone", tap_en, 64'(32'h1 << (old_pos + 1)));
        wait_n(2);
        inc = 1'b1;
        wait_n(5);

        // R3: saturation at both ends
        for (int k = 0; k < 20; k++) pulse(1'b1);
        chk("R3 top saturation", wiper, 31);
        chk("R8 top tap", tap_en, 64'(32'h8000_0000));
        for (int k = 0; k < 40; k++) pulse(1'b0);
        chk("R3 bottom saturation", wiper, 0);
        chk("R8 bottom tap", tap_en, 64'(32'h1));

        // R5: move to 5, release with strobe low
        for (int k = 0; k < 4; k++) pulse(1'b1);
        busy_cnt = 0;
        dir = 1'b1;
        wait_n(3);
        inc = 1'b0;
        wait_n(5);
        sel_n = 1'b1;
        wait_n(8);
        inc = 1'b1;
        wait_n(5);
        chk("R5 no busy", busy_cnt, 0);
        chk("R5 live pos kept", wiper, 5);
        pulse(1'b1);
        chk("R1 deselected after discard", wiper, 5);
        do_reset();
        chk("R5 R7 recall old committed", wiper, DEF_POS);

        // R4 / R6: move to 20, release with strobe high
        select();
        for (int k = 0; k < 4; k++) pulse(1'b1);
        chk("R2 pos before store", wiper, 20);
        busy_cnt = 0;
        sel_n = 1'b1;
        n = 0;
        while (!busy && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk("R4 busy raised", busy, 1);
        // Full select, step and release inside the store window
        sel_n = 1'b0;
        dir = 1'b1;
        wait_n(4);
        inc = 1'b0;
        wait_n(4);
        inc = 1'b1;
        wait_n(4);
        sel_n = 1'b1;
        n = 0;
        while (busy && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R4 busy length", busy_cnt, STORE_CYC);
        wait_n(10);
        chk("R6 pos unchanged", wiper, 20);
        chk("R6 no second store", busy, 0);
        do_reset();
        chk("R4 R7 recall committed", wiper, 20);
        chk("R8 recall tap", tap_en, 64'(32'h1 << 20));

        finish_run();
    end

endmodule